// File: doc/BRIEF.md
# Single-Entry Data Cache Store Buffer

This block sits between the load/store pipeline and a two-way set-associative data array. A store presents its cache index, way, data, byte enables and write policy together with the result of the tag comparison that runs in the same cycle. On a tag hit the store is held in a one-deep entry. The entry is written into the array during the first later cycle in which no load uses the array. A cycle with a store never carries a load, so one store per cycle is sustained with no stall: each new store pushes the previous entry into the array and takes its place.

Loads read the array with a one-cycle latency. A load that targets the pending location gets the held bytes merged over the array word according to the held byte enables. Every stored byte carries a parity bit that is generated when the array is written. Write-back stores mark their line dirty. Write-through stores leave the dirty bit alone and also raise a one-cycle memory write request. A store whose tag comparison misses is dropped and reported to the pipeline.

The array location is {way, set, word}. The cache index `st_idx`/`ld_idx` is {set, word}, with the word-in-line field in the low bits. A dirty bit belongs to line {way, set}. Store and load are never presented in the same cycle.

Top module: `stbuf_top`

## Requirements
- R1: A store with `st_tag_hit`=1 occupies the entry from the next cycle. It is written at the end of the first later cycle with `ld_valid`=0, and only the bytes whose `st_be` bit is set change at location {way, idx}.
- R2: While every cycle carries a load, the pending entry is held unchanged and the array is not written.
- R3: Consecutive stores, one per cycle, all reach the array with no stall. A later store to the same location overrides the overlapping bytes of an earlier one.
- R4: A store with `st_tag_hit`=0 raises `st_miss` in the next cycle for one cycle. Nothing is written for it, and an entry already pending still drains.
- R5: A load issued in cycle T returns `ld_rvalid`=1 and `ld_data` in cycle T+1. If the load's {way, idx} matches the pending entry, byte b is the pending byte when that entry's enable b is set, and the array byte otherwise.
- R6: `ld_par[b]` is the XOR of the eight bits of byte b of `ld_data` (bits 8b+7..8b), both for array bytes and for forwarded bytes.
- R7: A store with `st_wthru`=1 gives `mem_wr_valid`=1 in the next cycle, with its index, data and byte enables. A store with `st_wthru`=0 gives `mem_wr_valid`=0.
- R8: Writing a write-back entry sets the dirty bit of line {way, set}, where set is bits [6:2] of the index. Writing a write-through entry leaves that bit unchanged. `dq_dirty` reports the bit of the line presented on `dq_line` one cycle earlier.
- R9: After reset, `ld_rvalid`, `st_miss` and `mem_wr_valid` are 0, no entry is pending, and every dirty bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store issued this cycle |
| st_idx | input | 7 | Store cache index {set, word} |
| st_way | input | 1 | Way selected by the store's tag comparison |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| st_wthru | input | 1 | Store page is write-through |
| st_tag_hit | input | 1 | Tag comparison result for this store |
| ld_valid | input | 1 | Load uses the array this cycle |
| ld_idx | input | 7 | Load cache index |
| ld_way | input | 1 | Way selected by the load's tag comparison |
| ld_rvalid | output | 1 | Load data valid |
| ld_data | output | 64 | Load data with forwarding applied |
| ld_par | output | 8 | Per-byte parity of ld_data |
| st_miss | output | 1 | Previous store missed in the tags |
| mem_wr_valid | output | 1 | Write-through memory request |
| mem_wr_idx | output | 7 | Request cache index |
| mem_wr_data | output | 64 | Request data |
| mem_wr_be | output | 8 | Request byte enables |
| dq_line | input | 6 | Dirty lookup line {way, set} |
| dq_dirty | output | 1 | Dirty bit of the line looked up last cycle |

## Verification
The hardest case is a load that meets a held store: the entry must stay pending across one or more load cycles while the array still holds older bytes at the same location. The stimulus first writes a known full word and lets it drain. It then issues a partial store and follows it at once with a run of loads to the same location, so that every cycle after the store is a load cycle. A later idle cycle lets the entry drain, and a final load confirms that the merged value came to rest in the array. Back-to-back stores to one location and a missing store issued right behind a pending hit are built the same way, by chaining store calls with no idle cycle between them.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {WR_BACK = 1'b0, WR_THRU = 1'b1} wpol_e;

  function automatic logic byte_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/stbuf_entry.sv
module stbuf_entry import stbuf_pkg::*; #(
  parameter int AW = 8,
  parameter int DW = 64,
  localparam int NB = DW / BYTE_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          cap_hit,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  input  logic [NB-1:0] cap_be,
  input  wpol_e         cap_pol,
  input  logic          drain,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  output logic          pend_valid,
  output logic [AW-1:0] pend_addr,
  output logic [DW-1:0] pend_data,
  output logic [NB-1:0] pend_be,
  output wpol_e         pend_pol,
  output logic [NB-1:0] fwd_mask
);
  always_ff @(posedge clk) begin
    if (rst) pend_valid <= 1'b0;
    else if (cap_en) pend_valid <= cap_hit;
    else if (drain) pend_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      pend_addr <= cap_addr;
      pend_data <= cap_data;
      pend_be   <= cap_be;
      pend_pol  <= cap_pol;
    end
  end

  assign fwd_mask = (pend_valid && ld_en && pend_addr == ld_addr) ? pend_be : '0;
endmodule

// File: rtl/stbuf_array.sv
module stbuf_array import stbuf_pkg::*; #(
  parameter int AW = 8,
  parameter int NB = 8,
  localparam int DEPTH = 1 << AW
)(
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [NB*BYTE_W-1:0] wdata,
  input  logic [NB-1:0]        wbe,
  input  logic                 re,
  input  logic [AW-1:0]        raddr,
  output logic [NB*BYTE_W-1:0] rdata,
  output logic [NB-1:0]        rpar
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BYTE_W:0] lane [DEPTH];
    logic [BYTE_W:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wbe[b])
        lane[waddr] <= {byte_par(wdata[b*BYTE_W +: BYTE_W]), wdata[b*BYTE_W +: BYTE_W]};
      if (re) rd_q <= lane[raddr];
    end
    assign rdata[b*BYTE_W +: BYTE_W] = rd_q[BYTE_W-1:0];
    assign rpar[b] = rd_q[BYTE_W];
  end
endmodule

// File: rtl/stbuf_dirty.sv
module stbuf_dirty #(
  parameter int LW = 6,
  localparam int NL = 1 << LW
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          mark,
  input  logic [LW-1:0] mark_line,
  input  logic [LW-1:0] q_line,
  output logic          q_dirty
);
  logic [NL-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else if (mark) bits[mark_line] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q_dirty <= 1'b0;
    else q_dirty <= bits[q_line];
  end
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top import stbuf_pkg::*; #(
  parameter int SETS = 32,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W = 64,
  localparam int SET_W = $clog2(SETS),
  localparam int WRD_W = $clog2(LINE_WORDS),
  localparam int IDX_W = SET_W + WRD_W,
  localparam int AW = IDX_W + 1,
  localparam int LW = SET_W + 1,
  localparam int NB = DATA_W / BYTE_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic              st_way,
  input  logic [DATA_W-1:0] st_data,
  input  logic [NB-1:0]     st_be,
  input  logic              st_wthru,
  input  logic              st_tag_hit,
  input  logic              ld_valid,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic              ld_way,
  output logic              ld_rvalid,
  output logic [DATA_W-1:0] ld_data,
  output logic [NB-1:0]     ld_par,
  output logic              st_miss,
  output logic              mem_wr_valid,
  output logic [IDX_W-1:0]  mem_wr_idx,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [NB-1:0]     mem_wr_be,
  input  logic [LW-1:0]     dq_line,
  output logic              dq_dirty
);
  logic              pend_valid;
  logic [AW-1:0]     pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [NB-1:0]     pend_be;
  wpol_e             pend_pol;
  logic [NB-1:0]     fwd_mask;
  logic              arr_we;
  logic [DATA_W-1:0] arr_rdata;
  logic [NB-1:0]     arr_rpar;
  logic [NB-1:0]     fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;

  // a store cycle is never a load cycle, so it always frees the array
  assign arr_we = pend_valid & ~ld_valid;

  stbuf_entry #(.AW(AW), .DW(DATA_W)) u_entry (
    .clk(clk), .rst(rst),
    .cap_en(st_valid), .cap_hit(st_tag_hit), .cap_addr({st_way, st_idx}),
    .cap_data(st_data), .cap_be(st_be), .cap_pol(wpol_e'(st_wthru)),
    .drain(arr_we), .ld_en(ld_valid), .ld_addr({ld_way, ld_idx}),
    .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_data(pend_data),
    .pend_be(pend_be), .pend_pol(pend_pol), .fwd_mask(fwd_mask)
  );

  stbuf_array #(.AW(AW), .NB(NB)) u_array (
    .clk(clk), .we(arr_we), .waddr(pend_addr), .wdata(pend_data), .wbe(pend_be),
    .re(ld_valid), .raddr({ld_way, ld_idx}), .rdata(arr_rdata), .rpar(arr_rpar)
  );

  stbuf_dirty #(.LW(LW)) u_dirty (
    .clk(clk), .rst(rst),
    .mark(arr_we && pend_pol == WR_BACK), .mark_line(pend_addr[AW-1:WRD_W]),
    .q_line(dq_line), .q_dirty(dq_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_rvalid    <= 1'b0;
      st_miss      <= 1'b0;
      mem_wr_valid <= 1'b0;
      fwd_mask_q   <= '0;
    end else begin
      ld_rvalid    <= ld_valid;
      st_miss      <= st_valid & ~st_tag_hit;
      mem_wr_valid <= st_valid & st_wthru;
      fwd_mask_q   <= fwd_mask;
    end
  end

  always_ff @(posedge clk) begin
    fwd_data_q <= pend_data;
    if (st_valid) begin
      mem_wr_idx  <= st_idx;
      mem_wr_data <= st_data;
      mem_wr_be   <= st_be;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    always_comb begin
      if (fwd_mask_q[b]) begin
        ld_data[b*BYTE_W +: BYTE_W] = fwd_data_q[b*BYTE_W +: BYTE_W];
        ld_par[b] = byte_par(fwd_data_q[b*BYTE_W +: BYTE_W]);
      end else begin
        ld_data[b*BYTE_W +: BYTE_W] = arr_rdata[b*BYTE_W +: BYTE_W];
        ld_par[b] = arr_rpar[b];
      end
    end
  end
endmodule

// File: rtl/stbuf_checker.sv
module stbuf_checker #(
  parameter int DW = 64
)(
  input logic          clk,
  input logic          rst,
  input logic          st_valid,
  input logic          st_tag_hit,
  input logic          st_wthru,
  input logic          ld_valid,
  input logic          ld_rvalid,
  input logic          st_miss,
  input logic          mem_wr_valid,
  input logic          pend_valid,
  input logic [DW-1:0] pend_data,
  input logic          arr_we
);
  a_r1_entry_on_hit: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_tag_hit |=> pend_valid);

  a_r2_hold_under_load: assert property (@(posedge clk) disable iff (rst)
    pend_valid && ld_valid && !st_valid |=> pend_valid && $stable(pend_data));

  a_r2_no_write_on_load: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> !arr_we);

  a_r3_released_when_free: assert property (@(posedge clk) disable iff (rst)
    pend_valid && !ld_valid && !st_valid |=> !pend_valid);

  a_r4_miss_reported: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_tag_hit |=> st_miss && !pend_valid);

  a_r5_load_returns: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> ld_rvalid);

  a_r7_wt_request: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_wthru |=> mem_wr_valid);

  a_r7_no_wb_request: assert property (@(posedge clk) disable iff (rst)
    !(st_valid && st_wthru) |=> !mem_wr_valid);
endmodule

bind stbuf_top stbuf_checker #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_tag_hit(st_tag_hit),
  .st_wthru(st_wthru), .ld_valid(ld_valid), .ld_rvalid(ld_rvalid),
  .st_miss(st_miss), .mem_wr_valid(mem_wr_valid), .pend_valid(pend_valid),
  .pend_data(pend_data), .arr_we(arr_we)
);

// File: tb/tb_stbuf_top.sv
module tb_stbuf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [6:0]  st_idx = '0;
  logic        st_way = 1'b0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        st_wthru = 1'b0;
  logic        st_tag_hit = 1'b0;
  logic        ld_valid = 1'b0;
  logic [6:0]  ld_idx = '0;
  logic        ld_way = 1'b0;
  logic        ld_rvalid;
  logic [63:0] ld_data;
  logic [7:0]  ld_par;
  logic        st_miss;
  logic        mem_wr_valid;
  logic [6:0]  mem_wr_idx;
  logic [63:0] mem_wr_data;
  logic [7:0]  mem_wr_be;
  logic [5:0]  dq_line = '0;
  logic        dq_dirty;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stbuf_top dut (.*);

  function automatic logic [63:0] merge(input logic [63:0] old_w, input logic [63:0] new_w,
                                        input logic [7:0] be);
    logic [63:0] r = old_w;
    for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] par_of(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    st_valid = 1'b0; ld_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_store(input logic way, input logic [6:0] idx, input logic [63:0] d,
                          input logic [7:0] be, input logic hit, input logic wt);
    ld_valid = 1'b0;
    st_valid = 1'b1; st_way = way; st_idx = idx; st_data = d;
    st_be = be; st_tag_hit = hit; st_wthru = wt;
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic way, input logic [6:0] idx,
                         output logic [63:0] d, output logic [7:0] p, output logic v);
    st_valid = 1'b0;
    ld_valid = 1'b1; ld_way = way; ld_idx = idx;
    @(negedge clk);
    ld_valid = 1'b0;
    d = ld_data; p = ld_par; v = ld_rvalid;
  endtask

  task automatic query(input logic [5:0] line, output logic d);
    dq_line = line;
    @(negedge clk);
    d = dq_dirty;
  endtask

  // R9: reset state
  task automatic t_reset();
    logic d;
    chk("R9 ld_rvalid", 64'(ld_rvalid), 64'd0);
    chk("R9 st_miss", 64'(st_miss), 64'd0);
    chk("R9 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
    query(6'd0, d);  chk("R9 dirty line0", 64'(d), 64'd0);
    query(6'd63, d); chk("R9 dirty line63", 64'(d), 64'd0);
  endtask

  // R1, R5, R6: full write then partial write, read back from the array
  task automatic t_write();
    logic [63:0] d; logic [7:0] p; logic v;
    do_store(1'b0, 7'd5, 64'h0123_4567_89AB_CDEF, 8'hFF, 1'b1, 1'b0);
    idle();
    do_load(1'b0, 7'd5, d, p, v);
    chk("R5 rvalid", 64'(v), 64'd1);
    chk("R1 full write", d, 64'h0123_4567_89AB_CDEF);
    chk("R6 parity full", 64'(p), 64'(par_of(64'h0123_4567_89AB_CDEF)));
    do_store(1'b0, 7'd5, 64'hFFEE_DDCC_1357_9BDF, 8'h0F, 1'b1, 1'b0);
    idle();
    do_load(1'b0, 7'd5, d, p, v);
    chk("R1 partial write", d, 64'h0123_4567_1357_9BDF);
    chk("R6 parity partial", 64'(p), 64'(par_of(64'h0123_4567_1357_9BDF)));
  endtask

  // R2, R5, R6: entry held across loads and forwarded
  task automatic t_forward();
    logic [63:0] d; logic [7:0] p; logic v;
    logic [63:0] exp_w = merge(64'h0123_4567_1357_9BDF, 64'hA5A5_0F0F_0000_0000, 8'hF0);
    do_store(1'b0, 7'd5, 64'hA5A5_0F0F_0000_0000, 8'hF0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      do_load(1'b0, 7'd5, d, p, v);
      chk("R5 forward merge", d, exp_w);
      chk("R6 forward parity", 64'(p), 64'(par_of(exp_w)));
    end
    do_load(1'b1, 7'd5, d, p, v);
    chk("R2 other way not forwarded rvalid", 64'(v), 64'd1);
    idle();
    do_load(1'b0, 7'd5, d, p, v);
    chk("R2 drained after loads", d, exp_w);
  endtask

  // R3: consecutive stores, including two to one location
  task automatic t_b2b();
    logic [63:0] d; logic [7:0] p; logic v;
    do_store(1'b1, 7'd10, 64'h1111_2222_3333_4444, 8'hFF, 1'b1, 1'b0);
    do_store(1'b1, 7'd11, 64'h5555_6666_7777_8888, 8'hFF, 1'b1, 1'b0);
    do_store(1'b1, 7'd12, 64'h9999_AAAA_BBBB_CCCC, 8'hFF, 1'b1, 1'b0);
    do_store(1'b1, 7'd12, 64'h0000_0000_DEAD_BEEF, 8'h0F, 1'b1, 1'b0);
    idle();
    do_load(1'b1, 7'd10, d, p, v); chk("R3 b2b first", d, 64'h1111_2222_3333_4444);
    do_load(1'b1, 7'd11, d, p, v); chk("R3 b2b second", d, 64'h5555_6666_7777_8888);
    do_load(1'b1, 7'd12, d, p, v); chk("R3 b2b same location", d, 64'h9999_AAAA_DEAD_BEEF);
  endtask

  // R4: miss right behind a pending hit
  task automatic t_miss();
    logic [63:0] d; logic [7:0] p; logic v;
    do_store(1'b0, 7'd20, 64'hCAFE_F00D_1234_5678, 8'hFF, 1'b1, 1'b0);
    do_store(1'b0, 7'd5, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0, 1'b0);
    chk("R4 miss flag", 64'(st_miss), 64'd1);
    idle();
    chk("R4 miss flag one cycle", 64'(st_miss), 64'd0);
    do_load(1'b0, 7'd20, d, p, v); chk("R4 pending hit still drained", d, 64'hCAFE_F00D_1234_5678);
    do_load(1'b0, 7'd5, d, p, v);
    chk("R4 missed store not written", d,
        merge(64'h0123_4567_1357_9BDF, 64'hA5A5_0F0F_0000_0000, 8'hF0));
  endtask

  // R7: write-through request
  task automatic t_wthru();
    do_store(1'b0, 7'd40, 64'h0BAD_C0DE_7654_3210, 8'h3C, 1'b1, 1'b1);
    chk("R7 request valid", 64'(mem_wr_valid), 64'd1);
    chk("R7 request idx", 64'(mem_wr_idx), 64'd40);
    chk("R7 request data", mem_wr_data, 64'h0BAD_C0DE_7654_3210);
    chk("R7 request be", 64'(mem_wr_be), 64'h3C);
    do_store(1'b0, 7'd41, 64'h1, 8'hFF, 1'b1, 1'b0);
    chk("R7 no request for write-back", 64'(mem_wr_valid), 64'd0);
    idle();
  endtask

  // R8: dirty marking; line {way1,set7}=39, index 29 is set 7 word 1
  task automatic t_dirty();
    logic d;
    query(6'd39, d); chk("R8 initially clean", 64'(d), 64'd0);
    do_store(1'b1, 7'd29, 64'h77, 8'h01, 1'b1, 1'b1);
    idle();
    query(6'd39, d); chk("R8 write-through stays clean", 64'(d), 64'd0);
    do_store(1'b1, 7'd29, 64'h88, 8'h01, 1'b1, 1'b0);
    idle();
    query(6'd39, d); chk("R8 write-back marks dirty", 64'(d), 64'd1);
    query(6'd7, d);  chk("R8 other way untouched", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write();
    t_forward();
    t_b2b();
    t_miss();
    t_wthru();
    t_dirty();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule